// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a 36-bit FIFO word path and an external port that may be 36, 18 or 9 bits wide. Data arriving on the narrow write port is collected piece by piece into a full word, and only a finished word is offered to the FIFO through a push handshake. Words leaving the FIFO are taken through a pop handshake and handed out one piece at a time on the read port. The FIFO storage and its flags live outside the block.

The port width and the piece order are chosen by two configuration inputs. Both are captured while the full reset is held and then kept, even through the data-only reset. In big-endian order the most significant piece of a word moves first. In little-endian order the least significant piece moves first. At 36 bits a word passes straight through in one transfer. Narrow pieces always use the low bits of the 36-bit data ports.

Top module: `bus_match_conv`

## Requirements
- R1: With `cfg_width` = 0 (36 bits), every accepted write word is pushed unchanged, and every popped word appears unchanged as a single read transfer.
- R2: With `cfg_width` = 1 (18 bits), two write pieces form one pushed word. The first piece fills bits 35:18 when `cfg_big` = 1 and bits 17:0 when `cfg_big` = 0.
- R3: With `cfg_width` = 2 (9 bits), four write pieces form one pushed word. In big-endian order the first piece fills bits 35:27 and the last fills 8:0. Little-endian order is the reverse.
- R4: In 18-bit and 9-bit modes a popped word is sent out as 2 or 4 read pieces. The order matches R2/R3: big-endian sends the most significant piece first, and little-endian sends the least significant piece first.
- R5: In narrow modes only `wr_data` bits below the piece width are used. On `rd_data`, the bits above the piece width read as zero.
- R6: `push_valid` rises only after the last piece of a word has been accepted. While `push_ready` is low, `push_valid` and `push_data` hold steady.
- R7: A word is popped only when no word is held or when the last piece of the held word is being taken in the same cycle. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady.
- R8: Width and order are loaded from `cfg_width`/`cfg_big` on every clock while `rst_all` is high. At all other times, including during `rst_data`, they ignore those inputs.
- R9: `rst_data` clears both piece counters and any held or assembled word. A partial word written before it is discarded, and the next word needs a full set of pieces.
- R10: After `rst_all`, `push_valid` and `rd_valid` are low and `wr_ready` is high. While either reset is high, `wr_ready` and `pop_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_all | input | 1 | Synchronous full reset; also loads the configuration |
| rst_data | input | 1 | Synchronous data reset; configuration kept |
| cfg_width | input | 2 | Port width select: 0 = 36, 1 = 18, 2 = 9, 3 = 36 |
| cfg_big | input | 1 | 1 = most significant piece first |
| wr_valid | input | 1 | Write piece offered |
| wr_ready | output | 1 | Write piece accepted this cycle when valid |
| wr_data | input | 36 | Write piece (low bits in narrow modes) |
| push_valid | output | 1 | Full word available for the FIFO |
| push_ready | input | 1 | FIFO can take a word |
| push_data | output | 36 | Word pushed into the FIFO |
| pop_valid | input | 1 | FIFO holds a word |
| pop_ready | output | 1 | Word taken from the FIFO this cycle when valid |
| pop_data | input | 36 | Head word of the FIFO |
| rd_valid | output | 1 | Read piece available |
| rd_ready | input | 1 | Consumer takes the read piece |
| rd_data | output | 36 | Read piece (low bits in narrow modes, rest zero) |

## Verification
The embedded properties watch, on every cycle, that a stalled push or read keeps its data steady, that a pop is always followed by a presented piece, that the captured configuration never moves outside the full reset, and that the data reset empties both paths. The placement and order of pieces within a word, the zeroing of unused read bits, and the loss of a half-written word after a data reset can only be seen by the bench scenarios. These scenarios run random words through the bench's own FIFO model for every width and order combination, and compare them against directed words whose expected values were worked out by hand.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;

    localparam int unsigned DEF_LANE_W = 9;
    localparam int unsigned DEF_LANES  = 4;

    typedef enum logic [1:0] {
        W_LONG = 2'd0,
        W_HALF = 2'd1,
        W_BYTE = 2'd2
    } width_e;

    typedef struct packed {
        width_e width;
        logic   big;
    } cfg_t;

    // Code 3 is not a distinct width; it falls back to full width.
    function automatic width_e decode_width(input logic [1:0] sel);
        case (sel)
            2'd1:    return W_HALF;
            2'd2:    return W_BYTE;
            default: return W_LONG;
        endcase
    endfunction

endpackage

// File: rtl/bmc_cfg.sv
`timescale 1ns/1ps
module bmc_cfg
    import bmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_all,
    input  logic [1:0] sel_width,
    input  logic       sel_big,
    output cfg_t       cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst_all) begin
            cfg_d.width = decode_width(sel_width);
            cfg_d.big   = sel_big;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R8: configuration frozen outside full reset
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst_all)
        1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/bmc_gather.sv
`timescale 1ns/1ps
module bmc_gather
    import bmc_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES
) (
    input  logic                       clk,
    input  logic                       rst_all,
    input  logic                       rst_data,
    input  cfg_t                       cfg,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [LANE_W*LANES-1:0]    wr_data,
    output logic                       push_valid,
    input  logic                       push_ready,
    output logic [LANE_W*LANES-1:0]    push_data
);

    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned CNT_W  = $clog2(LANES);
    localparam int unsigned HL     = LANES / 2;

    typedef struct packed {
        logic [WORD_W-1:0] asm_word;
        logic [WORD_W-1:0] out_word;
        logic [CNT_W-1:0]  cnt;
        logic              full;
    } gst_t;

    gst_t st_d, st_q;

    logic              any_rst;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  slot;
    logic              at_last;
    logic              accept;
    logic [WORD_W-1:0] merged;

    assign any_rst = rst_all | rst_data;

    always_comb begin
        case (cfg.width)
            W_HALF:  last_idx = CNT_W'(1);
            W_BYTE:  last_idx = CNT_W'(LANES - 1);
            default: last_idx = '0;
        endcase
        slot    = cfg.big ? (last_idx - st_q.cnt) : st_q.cnt;
        at_last = (st_q.cnt == last_idx);
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [CNT_W-1:0] lane_slot;
        logic [CNT_W-1:0] lane_sub;
        always_comb begin
            case (cfg.width)
                W_HALF: begin
                    lane_slot = CNT_W'(b / HL);
                    lane_sub  = CNT_W'(b % HL);
                end
                W_BYTE: begin
                    lane_slot = CNT_W'(b);
                    lane_sub  = '0;
                end
                default: begin
                    lane_slot = '0;
                    lane_sub  = CNT_W'(b);
                end
            endcase
        end
        assign merged[b*LANE_W +: LANE_W] = (lane_slot == slot)
            ? wr_data[int'(lane_sub)*LANE_W +: LANE_W]
            : st_q.asm_word[b*LANE_W +: LANE_W];
    end

    always_comb begin
        wr_ready = !any_rst && (!at_last || !st_q.full || push_ready);
        accept   = wr_valid && wr_ready;
        st_d     = st_q;
        if (st_q.full && push_ready) begin
            st_d.full = 1'b0;
        end
        if (accept) begin
            if (at_last) begin
                st_d.out_word = merged;
                st_d.full     = 1'b1;
                st_d.cnt      = '0;
            end else begin
                st_d.asm_word = merged;
                st_d.cnt      = st_q.cnt + CNT_W'(1);
            end
        end
        if (any_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign push_valid = st_q.full;
    assign push_data  = st_q.out_word;

    // R6: a stalled push keeps its word
    p_push_hold_r6: assert property (@(posedge clk) disable iff (any_rst)
        push_valid && !push_ready |=> push_valid && $stable(push_data));

    // R9: data reset empties the write path
    p_wr_clear_r9: assert property (@(posedge clk) disable iff (rst_all)
        rst_data |=> !push_valid && (st_q.cnt == '0));

    // R3: piece counter stays inside the word
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (any_rst)
        1'b1 |=> st_q.cnt <= last_idx);

endmodule

// File: rtl/bmc_split.sv
`timescale 1ns/1ps
module bmc_split
    import bmc_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES
) (
    input  logic                       clk,
    input  logic                       rst_all,
    input  logic                       rst_data,
    input  cfg_t                       cfg,
    input  logic                       pop_valid,
    output logic                       pop_ready,
    input  logic [LANE_W*LANES-1:0]    pop_data,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [LANE_W*LANES-1:0]    rd_data
);

    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned CNT_W  = $clog2(LANES);
    localparam int unsigned HL     = LANES / 2;

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
    } sst_t;

    sst_t st_d, st_q;

    logic             any_rst;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] slot;
    logic             take;
    logic             at_last;

    assign any_rst = rst_all | rst_data;

    always_comb begin
        case (cfg.width)
            W_HALF:  last_idx = CNT_W'(1);
            W_BYTE:  last_idx = CNT_W'(LANES - 1);
            default: last_idx = '0;
        endcase
        slot    = cfg.big ? (last_idx - st_q.cnt) : st_q.cnt;
        at_last = (st_q.cnt == last_idx);
    end

    for (genvar j = 0; j < LANES; j++) begin : g_out
        logic             src_en;
        logic [CNT_W-1:0] src;
        always_comb begin
            case (cfg.width)
                W_HALF: begin
                    src_en = (j < HL);
                    src    = CNT_W'(int'(slot) * HL + (j % HL));
                end
                W_BYTE: begin
                    src_en = (j == 0);
                    src    = slot;
                end
                default: begin
                    src_en = 1'b1;
                    src    = CNT_W'(j);
                end
            endcase
        end
        assign rd_data[j*LANE_W +: LANE_W] = src_en
            ? st_q.hold[int'(src)*LANE_W +: LANE_W]
            : '0;
    end

    always_comb begin
        take      = st_q.valid && rd_ready;
        pop_ready = !any_rst && (!st_q.valid || (take && at_last));
        st_d      = st_q;
        if (take) begin
            if (at_last) begin
                st_d.valid = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (pop_valid && pop_ready) begin
            st_d.hold  = pop_data;
            st_d.valid = 1'b1;
            st_d.cnt   = '0;
        end
        if (any_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;

    // R7: a stalled read piece keeps its value
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (any_rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R7: a popped word is presented on the next cycle
    p_pop_show_r7: assert property (@(posedge clk) disable iff (any_rst)
        pop_valid && pop_ready |=> rd_valid);

    // R9: data reset empties the read path
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (rst_all)
        rst_data |=> !rd_valid);

endmodule

// File: rtl/bus_match_conv.sv
`timescale 1ns/1ps
module bus_match_conv
    import bmc_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst_all,
    input  logic                    rst_data,
    input  logic [1:0]              cfg_width,
    input  logic                    cfg_big,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [LANE_W*LANES-1:0] wr_data,
    output logic                    push_valid,
    input  logic                    push_ready,
    output logic [LANE_W*LANES-1:0] push_data,
    input  logic                    pop_valid,
    output logic                    pop_ready,
    input  logic [LANE_W*LANES-1:0] pop_data,
    output logic                    rd_valid,
    input  logic                    rd_ready,
    output logic [LANE_W*LANES-1:0] rd_data
);

    cfg_t cfg;

    bmc_cfg u_cfg (
        .clk       (clk),
        .rst_all   (rst_all),
        .sel_width (cfg_width),
        .sel_big   (cfg_big),
        .cfg       (cfg)
    );

    bmc_gather #(.LANE_W(LANE_W), .LANES(LANES)) u_gather (
        .clk        (clk),
        .rst_all    (rst_all),
        .rst_data   (rst_data),
        .cfg        (cfg),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_data    (wr_data),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data)
    );

    bmc_split #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
        .clk       (clk),
        .rst_all   (rst_all),
        .rst_data  (rst_data),
        .cfg       (cfg),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_data  (pop_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/test_bus_match_conv.sv
`timescale 1ns/1ps
module test_bus_match_conv;

    logic        clk = 1'b0;
    logic        rst_all = 1'b1;
    logic        rst_data = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_big = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [35:0] wr_data = '0;
    logic        push_valid;
    logic        push_ready = 1'b0;
    logic [35:0] push_data;
    logic        pop_valid = 1'b0;
    logic        pop_ready;
    logic [35:0] pop_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [35:0] rd_data;

    always #2.5 clk = ~clk;

    bus_match_conv i_bus_match_conv (
        .clk(clk), .rst_all(rst_all), .rst_data(rst_data),
        .cfg_width(cfg_width), .cfg_big(cfg_big),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int mode_i = 0;
    bit big_i = 1'b0;
    int wcnt = 0;
    logic [35:0] partial = '0;
    logic [35:0] last_push = '0;
    logic [35:0] fifoq[$];
    logic [35:0] exp_push[$];
    logic [35:0] exp_rd[$];

    function automatic int npieces(input int m);
        return (m == 1) ? 2 : (m == 2) ? 4 : 1;
    endfunction

    function automatic int slot_of(input int k, input int m, input bit be);
        return be ? (npieces(m) - 1 - k) : k;
    endfunction

    function automatic logic [35:0] place(input logic [35:0] word, input logic [35:0] piece,
                                          input int k, input int m, input bit be);
        int w = 36 / npieces(m);
        int base = slot_of(k, m, be) * w;
        for (int i = 0; i < w; i++) word[base + i] = piece[i];
        return word;
    endfunction

    function automatic logic [35:0] extract(input logic [35:0] word, input int k,
                                            input int m, input bit be);
        logic [35:0] res = '0;
        int w = 36 / npieces(m);
        int base = slot_of(k, m, be) * w;
        for (int i = 0; i < w; i++) res[i] = word[base + i];
        return res;
    endfunction

    task automatic check_eq(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string wr_tag();
        return (mode_i == 0) ? "R1" : (mode_i == 1) ? "R2" : "R3";
    endfunction

    // One clock: drive at the falling edge, then resolve handshakes for the next rising edge.
    task automatic cyc(input bit wv, input logic [35:0] wd, input bit pr, input bit rr, input bit pv_en);
        @(negedge clk);
        wr_valid   = wv;
        wr_data    = wd;
        push_ready = pr;
        rd_ready   = rr;
        pop_valid  = pv_en && (fifoq.size() > 0);
        pop_data   = (fifoq.size() > 0) ? fifoq[0] : '0;
        cfg_width  = 2'($urandom);   // R8: must be ignored outside full reset
        cfg_big    = 1'($urandom);
        #1;
        if (push_valid && push_ready) begin
            if (exp_push.size() == 0) begin
                check_eq("R6", push_data, 36'h0);
                if (push_data === 36'h0) begin
                    errors++;
                    $display("FAIL R6 actual=push expected=no push");
                end
            end else begin
                check_eq(wr_tag(), push_data, exp_push.pop_front());
            end
            last_push = push_data;
            fifoq.push_back(push_data);
        end
        if (pop_valid && pop_ready) begin
            checks++;
            if (!(exp_rd.size() == 0 || (exp_rd.size() == 1 && rd_valid && rd_ready))) begin
                errors++;
                $display("FAIL R7 actual=%0d pieces left expected=0 or last taken", exp_rd.size());
            end
            void'(fifoq.pop_front());
            for (int k = 0; k < npieces(mode_i); k++)
                exp_rd.push_back(extract(pop_data, k, mode_i, big_i));
        end
        if (rd_valid && rd_ready) begin
            if (exp_rd.size() == 0) begin
                errors++;
                checks++;
                $display("FAIL R7 actual=%h expected=no read piece", rd_data);
            end else begin
                check_eq((mode_i == 0) ? "R1" : "R4", rd_data, exp_rd.pop_front());
            end
        end
        if (wr_valid && wr_ready) begin
            partial = place(partial, wd, wcnt, mode_i, big_i);
            wcnt++;
            if (wcnt == npieces(mode_i)) begin
                exp_push.push_back(partial);
                wcnt = 0;
            end
        end
    endtask

    task automatic clear_model();
        fifoq.delete();
        exp_push.delete();
        exp_rd.delete();
        wcnt = 0;
        partial = '0;
    endtask

    task automatic do_rst_all(input int m, input bit be);
        @(negedge clk);
        rst_all = 1'b1;
        wr_valid = 1'b0; pop_valid = 1'b0; push_ready = 1'b0; rd_ready = 1'b0;
        cfg_width = 2'(m);
        cfg_big = be;
        #1;
        check_eq("R10", {34'h0, wr_ready, pop_ready}, 36'h0);
        repeat (3) @(negedge clk);
        rst_all = 1'b0;
        clear_model();
        mode_i = m;
        big_i = be;
        #1;
        check_eq("R10", {33'h0, push_valid, rd_valid, wr_ready}, 36'h1);
    endtask

    task automatic do_rst_data();
        @(negedge clk);
        rst_data = 1'b1;
        wr_valid = 1'b0; pop_valid = 1'b0; push_ready = 1'b0; rd_ready = 1'b0;
        @(negedge clk);
        rst_data = 1'b0;
        clear_model();
        #1;
        check_eq("R9", {34'h0, push_valid, rd_valid}, 36'h0);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b1, 1'b1, 1'b1);
        check_eq("R6", 36'(exp_push.size()), 36'h0);
        check_eq("R7", 36'(fifoq.size() + exp_rd.size()), 36'h0);
    endtask

    task automatic run_random(input int n);
        for (int i = 0; i < n; i++) begin
            logic [35:0] r = 36'({$urandom(), $urandom()});
            cyc(($urandom % 4) != 0, r, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 3) != 0);
        end
    endtask

    initial begin
        void'($urandom(32'h1BADCAFE));

        // Directed: 9-bit big-endian order, junk in the unused high bits (R3, R5)
        do_rst_all(2, 1'b1);
        cyc(1'b1, {27'h7FFFFFF, 9'h011}, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, {27'h5555555, 9'h022}, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, {27'h2AAAAAA, 9'h033}, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, {27'h1234567, 9'h044}, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check_eq("R3", last_push, {9'h011, 9'h022, 9'h033, 9'h044});
        drain(20);

        // Directed: data reset drops a half word, width retained (R9, R8)
        cyc(1'b1, 36'h0A1, 1'b1, 1'b1, 1'b1);
        cyc(1'b1, 36'h0A2, 1'b1, 1'b1, 1'b1);
        do_rst_data();
        cyc(1'b1, 36'h101, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 36'h102, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 36'h103, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check_eq("R8", {35'h0, push_valid}, 36'h0);
        cyc(1'b1, 36'h104, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check_eq("R9", last_push, {9'h101, 9'h102, 9'h103, 9'h104});
        drain(20);

        // Directed: 18-bit little-endian order (R2), read pieces checked by model (R4)
        do_rst_all(1, 1'b0);
        cyc(1'b1, 36'h12345, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 36'hF2ABCD, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check_eq("R2", last_push, {18'h2ABCD, 18'h12345});
        drain(20);

        // Random round trips for every width and order (R1..R7)
        for (int m = 0; m < 3; m++) begin
            for (int be = 0; be < 2; be++) begin
                do_rst_all(m, 1'(be));
                run_random(300);
                drain(60);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule